// File: doc/BRIEF.md
# Torus Link Virtual-Channel Packetizer

This block carries traffic over a single point-to-point link between two neighbouring nodes of a three-dimensional torus. Four independent virtual channels share the link. On the transmit side, each channel source signals when it holds a complete 128-byte payload. A round-robin arbiter picks one of the eligible channels. The framer then sends, as one uninterrupted burst of 32-bit words, a header word, the 32 payload words and a CRC-32 word.

On the receive side, the deframer recomputes the CRC while the payload words are written speculatively into the queue of the channel named in the header. A packet whose CRC word matches is committed at once. A packet whose CRC word does not match is discarded, which raises a one-cycle error pulse and advances a saturating error counter. Each channel queue signals backpressure toward the far transmitter when it can no longer accept a further full packet. The transmitter will not open a packet on a channel while that channel's stop input is high. Packet order is kept within each channel. Nothing is forwarded beyond the adjacent node.

Top module: `vcl_link`

## Requirements
- R1: While reset is held and directly after it, tx_valid, tx_last, src_pop, rx_vc_stop, out_valid, rx_crc_err and rx_err_cnt are all zero.
- R2: A transmitted packet is 34 consecutive words with tx_valid high. Word 0 is the header {16'h0, tx_dest[13:0], channel[1:0]}. Words 1 to 32 are the payload words in the order the source delivers them. Word 33 is the CRC. tx_last is high on word 33 only.
- R3: The CRC word is CRC-32 with polynomial 0x04C11DB7 and an initial value of all ones. It is taken over the header and the 32 payload words, each word fed most-significant bit first, with no bit reflection and no final inversion.
- R4: The arbiter is round-robin. After a grant to channel c, the next grant goes to the first eligible channel in the order c+1, c+2, c+3, c (modulo 4). After reset, channel 0 has first priority.
- R5: A channel is eligible only while its src_rdy is high and its tx_vc_stop is low. No packet is started for any other channel.
- R6: Packets never interleave. At most one bit of src_pop is high in any cycle, and each packet pops exactly 32 words, all from its own channel.
- R7: After a packet with a correct CRC, its payload is readable from the queue of the channel named in header bits [1:0]. A cycle with out_req[c] high on a non-empty queue gives out_valid[c] and the next word on out_data one cycle later.
- R8: Packets of one channel leave its queue in the order they were received.
- R9: A packet whose CRC word does not match is discarded and leaves its queue unchanged. rx_crc_err pulses for one cycle, and rx_err_cnt rises by one, saturating at its maximum. The receiver then accepts the next packet normally.
- R10: rx_vc_stop[c] is high while the words committed in queue c, plus 32 for a packet of channel c still being received, exceed the queue capacity minus 32.
- R11: out_req[c] on an empty queue is ignored and produces no out_valid[c].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_rdy | input | 4 | Source holds at least one full payload, one bit per channel |
| src_data | input | 128 | Head word of each source, channel c at bits [32c+31:32c] |
| src_pop | output | 4 | Consume the head word of that channel's source this cycle |
| tx_dest | input | 14 | Target address placed in the header |
| tx_vc_stop | input | 4 | Far-end backpressure per channel |
| tx_valid | output | 1 | Transmit word valid |
| tx_data | output | 32 | Transmit word |
| tx_last | output | 1 | Final (CRC) word of a packet |
| rx_valid | input | 1 | Receive word valid |
| rx_data | input | 32 | Receive word |
| rx_vc_stop | output | 4 | Per-channel backpressure toward the far transmitter |
| rx_crc_err | output | 1 | One-cycle pulse on a discarded packet |
| rx_err_cnt | output | 8 | Saturating count of discarded packets |
| out_req | input | 4 | Read request per channel queue |
| out_valid | output | 4 | Read data valid per channel |
| out_data | output | 128 | Read data, channel c at bits [32c+31:32c] |

## Verification
The transmitter is wired back to the receiver. A single packet on one channel checks the frame layout and the CRC value against a value worked out separately. All four channels made ready together show the rotation order, which an arbiter with fixed priority would not follow. A channel forced to stop while another is ready shows that the stop input gates only its own channel. Three packets queued on one channel fill its receive queue, which shows the backpressure threshold and the release after a drain, and the payload tags show that order within the channel is kept. A CRC word flipped on the link shows that the payload is discarded, the error pulse and counter rise, and the next packet on the same channel is received.

// File: rtl/vcl_pkg.sv
package vcl_pkg;
  localparam int VC_NUM   = 4;
  localparam int CH_W     = 2;
  localparam int ADDR_W   = 14;
  localparam int WORD_W   = 32;
  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;

  // One 32-bit word into the CRC, MSB first, no reflection.
  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 31; i >= 0; i--) begin
      if (r[31] ^ d[i]) r = (r << 1) ^ CRC_POLY;
      else              r = r << 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/vcl_rr_pick.sv
module vcl_rr_pick
  import vcl_pkg::*;
(
  input  logic [VC_NUM-1:0] req,
  input  logic [CH_W-1:0]   prev,
  output logic              any,
  output logic [CH_W-1:0]   pick
);
  always_comb begin
    any  = 1'b0;
    pick = '0;
    for (int k = 1; k <= VC_NUM; k++) begin
      int j;
      j = (int'(prev) + k) % VC_NUM;
      if (!any && req[j]) begin
        any  = 1'b1;
        pick = CH_W'(j);
      end
    end
  end
endmodule

// File: rtl/vcl_tx_framer.sv
module vcl_tx_framer
  import vcl_pkg::*;
#(
  parameter int PAY_W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [VC_NUM-1:0]        src_rdy,
  input  logic [VC_NUM*WORD_W-1:0] src_data,
  output logic [VC_NUM-1:0]        src_pop,
  input  logic [ADDR_W-1:0]        dest,
  input  logic [VC_NUM-1:0]        vc_stop,
  output logic                     tx_valid,
  output logic [WORD_W-1:0]        tx_data,
  output logic                     tx_last
);
  localparam int CNT_W = $clog2(PAY_W + 2);

  logic              busy;
  logic [CNT_W-1:0]  cnt;
  logic [CH_W-1:0]   cur, prev, pick;
  logic              any;
  logic [31:0]       crc;
  logic [WORD_W-1:0] cur_word, hdr;

  vcl_rr_pick u_pick (.req(src_rdy & ~vc_stop), .prev(prev), .any(any), .pick(pick));

  assign cur_word = src_data[int'(cur)*WORD_W +: WORD_W];
  assign hdr      = {{(WORD_W-ADDR_W-CH_W){1'b0}}, dest, cur};

  always_comb begin
    for (int c = 0; c < VC_NUM; c++)
      src_pop[c] = busy && (cnt != '0) && (cnt <= CNT_W'(PAY_W)) && (int'(cur) == c);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      cnt      <= '0;
      cur      <= '0;
      prev     <= CH_W'(VC_NUM - 1);
      crc      <= '1;
      tx_valid <= 1'b0;
      tx_last  <= 1'b0;
      tx_data  <= '0;
    end else begin
      tx_valid <= 1'b0;
      tx_last  <= 1'b0;
      if (!busy) begin
        if (any) begin
          busy <= 1'b1;
          cur  <= pick;
          cnt  <= '0;
        end
      end else begin
        tx_valid <= 1'b1;
        cnt      <= cnt + 1'b1;
        if (cnt == '0) begin
          tx_data <= hdr;
          crc     <= crc_step('1, hdr);
        end else if (cnt <= CNT_W'(PAY_W)) begin
          tx_data <= cur_word;
          crc     <= crc_step(crc, cur_word);
        end else begin
          tx_data <= crc;
          tx_last <= 1'b1;
          busy    <= 1'b0;
          prev    <= cur;
        end
      end
    end
  end
endmodule

// File: rtl/vcl_rx_deframer.sv
module vcl_rx_deframer
  import vcl_pkg::*;
#(
  parameter int PAY_W = 32,
  parameter int ERR_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rx_valid,
  input  logic [WORD_W-1:0]        rx_data,
  output logic [VC_NUM-1:0]        wr_en,
  output logic [$clog2(PAY_W)-1:0] wr_off,
  output logic [VC_NUM-1:0]        commit,
  output logic [CH_W-1:0]          rcv_ch,
  output logic                     rcv_busy,
  output logic                     crc_err,
  output logic [ERR_W-1:0]         err_cnt
);
  localparam int CNT_W = $clog2(PAY_W + 2);
  localparam int OFF_W = $clog2(PAY_W);

  logic [CNT_W-1:0] cnt;
  logic [31:0]      crc;
  logic             in_pay, at_crc;

  assign in_pay   = (cnt != '0) && (cnt <= CNT_W'(PAY_W));
  assign at_crc   = (cnt == CNT_W'(PAY_W + 1));
  assign rcv_busy = (cnt != '0);
  assign wr_off   = OFF_W'(cnt - 1'b1);

  always_comb begin
    wr_en  = '0;
    commit = '0;
    if (rx_valid && in_pay)                   wr_en[rcv_ch]  = 1'b1;
    if (rx_valid && at_crc && rx_data == crc) commit[rcv_ch] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      rcv_ch  <= '0;
      crc     <= '1;
      crc_err <= 1'b0;
      err_cnt <= '0;
    end else begin
      crc_err <= 1'b0;
      if (rx_valid) begin
        if (cnt == '0) begin
          rcv_ch <= rx_data[CH_W-1:0];
          crc    <= crc_step('1, rx_data);
          cnt    <= CNT_W'(1);
        end else if (in_pay) begin
          crc <= crc_step(crc, rx_data);
          cnt <= cnt + 1'b1;
        end else begin
          cnt <= '0;
          if (rx_data != crc) begin
            crc_err <= 1'b1;
            if (err_cnt != '1) err_cnt <= err_cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/vcl_rx_queue.sv
module vcl_rx_queue
  import vcl_pkg::*;
#(
  parameter int PAY_W = 32,
  parameter int QPKTS = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [$clog2(PAY_W)-1:0] wr_off,
  input  logic [WORD_W-1:0]        wr_data,
  input  logic                     commit,
  input  logic                     resv,
  input  logic                     rd_req,
  output logic                     rd_valid,
  output logic [WORD_W-1:0]        rd_data,
  output logic                     stop
);
  localparam int DEPTH = PAY_W * QPKTS;
  localparam int AW    = $clog2(DEPTH);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW:0]       wptr, rptr, level;
  logic [AW+1:0]     need;
  logic              empty;

  assign level = wptr - rptr;
  assign empty = (level == '0);
  assign need  = (AW+2)'(level) + (resv ? (AW+2)'(PAY_W) : '0);

  // Speculative write above the committed pointer; a drop simply never commits.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr[AW-1:0] + AW'(wr_off)] <= wr_data;
    if (rd_req && !empty) rd_data <= mem[rptr[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr     <= '0;
      rptr     <= '0;
      rd_valid <= 1'b0;
      stop     <= 1'b0;
    end else begin
      rd_valid <= rd_req && !empty;
      if (rd_req && !empty) rptr <= rptr + 1'b1;
      if (commit) wptr <= wptr + (AW+1)'(PAY_W);
      stop <= need > (AW+2)'(DEPTH - PAY_W);
    end
  end
endmodule

// File: rtl/vcl_link.sv
module vcl_link
  import vcl_pkg::*;
#(
  parameter int PAY_BYTES = 128,
  parameter int QPKTS     = 2,
  parameter int ERR_W     = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [VC_NUM-1:0]        src_rdy,
  input  logic [VC_NUM*WORD_W-1:0] src_data,
  output logic [VC_NUM-1:0]        src_pop,
  input  logic [ADDR_W-1:0]        tx_dest,
  input  logic [VC_NUM-1:0]        tx_vc_stop,
  output logic                     tx_valid,
  output logic [WORD_W-1:0]        tx_data,
  output logic                     tx_last,
  input  logic                     rx_valid,
  input  logic [WORD_W-1:0]        rx_data,
  output logic [VC_NUM-1:0]        rx_vc_stop,
  output logic                     rx_crc_err,
  output logic [ERR_W-1:0]         rx_err_cnt,
  input  logic [VC_NUM-1:0]        out_req,
  output logic [VC_NUM-1:0]        out_valid,
  output logic [VC_NUM*WORD_W-1:0] out_data
);
  localparam int PAY_W = PAY_BYTES / (WORD_W / 8);
  localparam int OFF_W = $clog2(PAY_W);

  logic [VC_NUM-1:0] wr_en, commit;
  logic [OFF_W-1:0]  wr_off;
  logic [CH_W-1:0]   rcv_ch;
  logic              rcv_busy;

  vcl_tx_framer #(.PAY_W(PAY_W)) u_tx (
    .clk(clk), .rst(rst), .src_rdy(src_rdy), .src_data(src_data), .src_pop(src_pop),
    .dest(tx_dest), .vc_stop(tx_vc_stop), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_last(tx_last)
  );

  vcl_rx_deframer #(.PAY_W(PAY_W), .ERR_W(ERR_W)) u_rx (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data), .wr_en(wr_en),
    .wr_off(wr_off), .commit(commit), .rcv_ch(rcv_ch), .rcv_busy(rcv_busy),
    .crc_err(rx_crc_err), .err_cnt(rx_err_cnt)
  );

  for (genvar c = 0; c < VC_NUM; c++) begin : g_q
    vcl_rx_queue #(.PAY_W(PAY_W), .QPKTS(QPKTS)) u_q (
      .clk(clk), .rst(rst), .wr_en(wr_en[c]), .wr_off(wr_off), .wr_data(rx_data),
      .commit(commit[c]), .resv(rcv_busy && (int'(rcv_ch) == c)),
      .rd_req(out_req[c]), .rd_valid(out_valid[c]),
      .rd_data(out_data[c*WORD_W +: WORD_W]), .stop(rx_vc_stop[c])
    );
  end
endmodule

// File: rtl/vcl_link_chk.sv
module vcl_link_chk #(
  parameter int NVC   = 4,
  parameter int ERR_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [NVC-1:0]   src_pop,
  input logic             tx_valid,
  input logic             tx_last,
  input logic             rx_crc_err,
  input logic [ERR_W-1:0] rx_err_cnt,
  input logic [NVC-1:0]   out_req,
  input logic [NVC-1:0]   out_valid
);
  a_r6_pop_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(src_pop));

  a_r2_last_in_frame: assert property (@(posedge clk) disable iff (rst)
    tx_last |-> tx_valid);

  a_r2_last_single: assert property (@(posedge clk) disable iff (rst)
    tx_last |=> !tx_last);

  a_r9_cnt_follows_pulse: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_err_cnt) |-> rx_crc_err);

  a_r9_cnt_step_one: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_err_cnt) |-> rx_err_cnt == $past(rx_err_cnt) + 1'b1);

  a_r7_valid_needs_req: assert property (@(posedge clk) disable iff (rst)
    (out_valid & ~$past(out_req)) == '0);
endmodule

bind vcl_link vcl_link_chk #(.NVC(vcl_pkg::VC_NUM), .ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst(rst), .src_pop(src_pop), .tx_valid(tx_valid), .tx_last(tx_last),
  .rx_crc_err(rx_crc_err), .rx_err_cnt(rx_err_cnt), .out_req(out_req),
  .out_valid(out_valid)
);

// File: tb/vcl_link_test.sv
module vcl_link_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVC = 4;
  localparam int PW  = 32;
  localparam logic [13:0] DEST = 14'h1ABC;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NVC-1:0]      src_rdy, src_pop, tx_vc_stop, rx_vc_stop, out_req, out_valid;
  logic [NVC*32-1:0]   src_data, out_data;
  logic                tx_valid, tx_last, rx_valid, rx_crc_err;
  logic [31:0]         tx_data, rx_data;
  logic [7:0]          rx_err_cnt;
  logic [NVC-1:0]      force_stop = '0;
  logic                corrupt_en = 1'b0;

  int avail  [NVC];
  int popcnt [NVC];
  int txseq  [NVC];
  int rdseq  [NVC];
  int n_cmp = 0, n_bad = 0;

  logic [31:0] frm [32][34];
  int flen [32];
  logic [31:0] cur_f [34];
  int widx = 0, nfrm = 0, errpulses = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vcl_link uut (
    .clk(clk), .rst(rst), .src_rdy(src_rdy), .src_data(src_data), .src_pop(src_pop),
    .tx_dest(DEST), .tx_vc_stop(tx_vc_stop), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_last(tx_last), .rx_valid(rx_valid), .rx_data(rx_data), .rx_vc_stop(rx_vc_stop),
    .rx_crc_err(rx_crc_err), .rx_err_cnt(rx_err_cnt), .out_req(out_req),
    .out_valid(out_valid), .out_data(out_data)
  );

  // Link loopback with optional corruption of the CRC word.
  assign rx_valid   = tx_valid;
  assign rx_data    = tx_data ^ ((corrupt_en && tx_last) ? 32'h1 : 32'h0);
  assign tx_vc_stop = rx_vc_stop | force_stop;

  function automatic logic [31:0] pay_word(int c, int pkt, int w);
    return {8'(c), 8'(pkt), 8'(w), 8'hA5};
  endfunction

  always_comb begin
    for (int c = 0; c < NVC; c++) begin
      src_rdy[c] = (avail[c]*PW - popcnt[c]) >= PW;
      src_data[c*32 +: 32] = pay_word(c, popcnt[c]/PW, popcnt[c]%PW);
    end
  end

  always @(posedge clk) begin
    for (int c = 0; c < NVC; c++)
      if (rst) popcnt[c] <= 0;
      else if (src_pop[c]) popcnt[c] <= popcnt[c] + 1;
  end

  always @(negedge clk) begin
    if (!rst && rx_crc_err) errpulses++;
    if (!rst && tx_valid) begin
      if (widx < 34) cur_f[widx] = tx_data;
      widx++;
      if (tx_last) begin
        for (int i = 0; i < 34; i++) frm[nfrm%32][i] = cur_f[i];
        flen[nfrm%32] = widx;
        nfrm++;
        widx = 0;
      end
    end
  end

  function automatic logic [31:0] ref_crc(logic [31:0] c, logic [31:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 31; i >= 0; i--) begin
      logic fb;
      fb = r[31] ^ d[i];
      r  = r << 1;
      if (fb) r = r ^ 32'h04C11DB7;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_up;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic wait_frames(input int n);
    int lim;
    lim = 0;
    while (nfrm < n && lim < 3000) begin
      @(negedge clk);
      lim++;
    end
  endtask

  // R2 R3: layout and CRC of captured frame f, expected on channel ch
  task automatic chk_frame(input int f, input int ch);
    logic [31:0] hdr, crc, w;
    bit ok;
    int pkt;
    pkt = txseq[ch];
    txseq[ch]++;
    hdr = {16'h0, DEST, 2'(ch)};
    chk(flen[f%32] == 34, "R2 frame length", 32'(flen[f%32]), 32'd34);
    chk(frm[f%32][0] == hdr, "R2/R4 header", frm[f%32][0], hdr);
    crc = ref_crc(32'hFFFF_FFFF, hdr);
    ok = 1'b1;
    for (int i = 0; i < PW; i++) begin
      w = pay_word(ch, pkt, i);
      if (frm[f%32][i+1] != w) ok = 1'b0;
      crc = ref_crc(crc, w);
    end
    chk(ok, "R2/R6 payload words", frm[f%32][1], pay_word(ch, pkt, 0));
    chk(frm[f%32][33] == crc, "R3 crc word", frm[f%32][33], crc);
  endtask

  // R7 R8: read one packet from queue c and compare order tags
  task automatic drain(input int c);
    logic [31:0] exp;
    for (int i = 0; i < PW; i++) begin
      out_req[c] = 1'b1;
      @(negedge clk);
      out_req[c] = 1'b0;
      exp = pay_word(c, rdseq[c], i);
      chk(out_valid[c] == 1'b1, "R7 out_valid", 32'(out_valid[c]), 32'd1);
      chk(out_data[c*32 +: 32] == exp, "R7/R8 out_data", out_data[c*32 +: 32], exp);
      @(negedge clk);
    end
    rdseq[c]++;
  endtask

  task automatic t_reset;
    chk(tx_valid == 0 && tx_last == 0, "R1 tx idle", {30'h0, tx_valid, tx_last}, 32'h0);
    chk(src_pop == 0, "R1 src_pop", 32'(src_pop), 32'h0);
    chk(rx_vc_stop == 0, "R1 rx_vc_stop", 32'(rx_vc_stop), 32'h0);
    chk(out_valid == 0, "R1 out_valid", 32'(out_valid), 32'h0);
    chk(rx_err_cnt == 0 && rx_crc_err == 0, "R1 err", {23'h0, rx_crc_err, rx_err_cnt}, 32'h0);
  endtask

  task automatic t_single;
    int b;
    b = nfrm;
    avail[2]++;
    wait_frames(b + 1);
    chk_frame(b, 2);
    repeat (4) @(negedge clk);
    drain(2);
  endtask

  task automatic t_round_robin;
    int b;
    int order [4] = '{3, 0, 1, 2};
    b = nfrm;
    for (int c = 0; c < NVC; c++) avail[c]++;
    wait_frames(b + 4);
    for (int k = 0; k < 4; k++) begin
      chk(frm[(b+k)%32][0][1:0] == 2'(order[k]), "R4 grant order",
          32'(frm[(b+k)%32][0][1:0]), 32'(order[k]));
      chk_frame(b + k, order[k]);
    end
    repeat (4) @(negedge clk);
    for (int c = 0; c < NVC; c++) drain(c);
  endtask

  task automatic t_stop;
    int b;
    b = nfrm;
    force_stop[1] = 1'b1;
    avail[1]++;
    avail[3]++;
    wait_frames(b + 1);
    repeat (100) @(negedge clk);
    chk(nfrm == b + 1, "R5 stopped channel held", 32'(nfrm - b), 32'd1);
    chk_frame(b, 3);
    force_stop[1] = 1'b0;
    wait_frames(b + 2);
    chk_frame(b + 1, 1);
    repeat (4) @(negedge clk);
    drain(3);
    drain(1);
  endtask

  task automatic t_backpressure;
    int b;
    b = nfrm;
    avail[0] += 3;
    wait_frames(b + 2);
    repeat (120) @(negedge clk);
    chk(nfrm == b + 2, "R10 third packet held", 32'(nfrm - b), 32'd2);
    chk(rx_vc_stop[0] == 1'b1, "R10 stop raised", 32'(rx_vc_stop[0]), 32'd1);
    chk(rx_vc_stop[3:1] == 3'b000, "R10 other channels free", 32'(rx_vc_stop[3:1]), 32'd0);
    chk_frame(b, 0);
    chk_frame(b + 1, 0);
    drain(0);
    wait_frames(b + 3);
    chk_frame(b + 2, 0);
    repeat (4) @(negedge clk);
    drain(0);
    drain(0);
    repeat (3) @(negedge clk);
    chk(rx_vc_stop[0] == 1'b0, "R10 stop released", 32'(rx_vc_stop[0]), 32'd0);
  endtask

  task automatic t_crc_error;
    int b;
    b = nfrm;
    corrupt_en = 1'b1;
    avail[3]++;
    wait_frames(b + 1);
    corrupt_en = 1'b0;
    chk_frame(b, 3);
    repeat (4) @(negedge clk);
    chk(errpulses == 1, "R9 error pulse", 32'(errpulses), 32'd1);
    chk(rx_err_cnt == 8'd1, "R9 error count", 32'(rx_err_cnt), 32'd1);
    rdseq[3]++;
    out_req[3] = 1'b1;
    @(negedge clk);
    out_req[3] = 1'b0;
    chk(out_valid[3] == 1'b0, "R9/R11 dropped payload absent", 32'(out_valid[3]), 32'd0);
    avail[3]++;
    wait_frames(b + 2);
    chk_frame(b + 1, 3);
    repeat (4) @(negedge clk);
    chk(rx_err_cnt == 8'd1, "R9 count after good packet", 32'(rx_err_cnt), 32'd1);
    drain(3);
  endtask

  initial begin
    for (int c = 0; c < NVC; c++) begin
      avail[c] = 0; txseq[c] = 0; rdseq[c] = 0;
    end
    out_req = '0;
    repeat (4) @(negedge clk);
    t_reset;
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_single;
    t_round_robin;
    t_stop;
    t_backpressure;
    t_crc_error;
    finish_up;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
    finish_up;
  end
endmodule